// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR-flash data bus. It decides whether an embedded program or erase has finished. After a start pulse it issues status reads. It tracks the bit that the flash flips on every status read while an operation runs (data bit 6) and the timing-limit flag (data bit 5). When two consecutive reads return the same toggle value, the operation has ended and the block reports done.

If the toggle bit keeps flipping while the timing-limit flag is clear, the block keeps reading. Each new read is compared with the one before it. If the toggle bit flips and the timing-limit flag is set, the block takes one more pair of reads. This second look closes the race in which toggling stops just as the flag rises.

A pair that still differs on that second look means the operation failed. The block then writes the reset command (0xF0) to return the device to array reads, and raises fail. A programmable read budget makes sure that polling always ends.

The block has two data paths, both with back-pressure:
- **Read requests.** `rd_req` rises and stays high until `rd_done` returns the word on `rd_data` for one cycle. Each `rd_done` while `rd_req` is high completes exactly one read.
- **Command write.** `cmd_valid` and `cmd_data` hold steady until `cmd_ready` is seen high. The write is accepted on the cycle where both are high.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `rd_req` and `cmd_valid` are all 0.
- R2: A `start` pulse while idle raises `busy` and `rd_req` on the next cycle and clears `done` and `fail`.
- R3: Once raised, `rd_req` stays high until a cycle with `rd_done` high (or an abort). Each such cycle completes exactly one read.
- R4: Polling starts with two reads, and no decision is made on the first read. If bit 6 of the second read equals bit 6 of the first, `done` is 1 and `busy` and `rd_req` are 0 on the next cycle.
- R5: If the compared reads differ in bit 6 and bit 5 of the newer read is 0, polling continues. Each further read is compared with the read just before it.
- R6: If the compared reads differ in bit 6 and bit 5 of the newer read is 1, two more reads follow. If bit 6 matches between them, the block reports `done`.
- R7: If bit 6 still differs in that extra pair, the block raises `cmd_valid` with `cmd_data` = 0xF0 and issues no more reads.
- R8: `cmd_valid` holds until `cmd_ready`. On the cycle after the handshake, `fail` is 1 and `busy` is 0.
- R9: Suppose a compared pair differs with bit 5 = 0 and the total number of reads in this attempt has reached `max_polls`. Then the block issues the reset command and fails instead of reading again. A `max_polls` below 2 behaves as 2.
- R10: `abort` during the read phase returns the block to idle on the next cycle, with `done` and `fail` at 0. The next `start` begins again from the initial pair of reads, and no earlier read value is kept.
- R11: `done` and `fail` are never both 1. Each one holds its value until the next `start`.
- R12: `abort` has no effect while the reset command is waiting for `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a polling attempt (ignored while busy) |
| abort | input | 1 | Abandon polling during the read phase |
| max_polls | input | CNT_W | Read budget per attempt |
| rd_req | output | 1 | Status read request, held until completed |
| rd_done | input | 1 | Read completion; `rd_data` is valid this cycle |
| rd_data | input | DATA_W | Word returned by the status read |
| cmd_valid | output | 1 | Command write pending |
| cmd_ready | input | 1 | Command write accepted |
| cmd_data | output | DATA_W | Command word (reset code) |
| done | output | 1 | Operation finished successfully |
| fail | output | 1 | Operation failed; reset command was issued |
| busy | output | 1 | Attempt in progress |

## Verification
The bench builds the block with an 8-bit data bus and an 8-bit budget counter. Budgets of 4 and 1 can then be reached in a few reads, which exercises both the exhaustion path and the rule that clamps small limits to 2. The reset command is held under back-pressure for several cycles, and an abort is raised while it waits. After an abort, the restart uses a first read equal to the stale value. A design that kept the old reference would then finish early.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_NEXT,
    ST_RE_A,
    ST_RE_B,
    ST_RSTCMD
  } ftp_state_e;

  typedef enum logic [1:0] {
    V_STEADY,
    V_TOGGLE,
    V_TOGGLE_TMO
  } ftp_verdict_e;
endpackage

// File: rtl/ftp_judge.sv
module ftp_judge
  import ftp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TOG_POS = 6,
  parameter int TMO_POS = 5
) (
  input  logic              ref_bit,
  input  logic [DATA_W-1:0] word,
  output ftp_verdict_e      verdict
);
  logic tog_now, tmo_now;
  assign tog_now = word[TOG_POS];
  assign tmo_now = word[TMO_POS];

  always_comb begin
    if (tog_now == ref_bit)  verdict = V_STEADY;
    else if (tmo_now)        verdict = V_TOGGLE_TMO;
    else                     verdict = V_TOGGLE;
  end
endmodule

// File: rtl/ftp_budget.sv
module ftp_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  localparam logic [CNT_W-1:0] MIN_LIM = CNT_W'(2);
  localparam logic [CNT_W-1:0] SAT     = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] eff;

  assign eff  = (limit < MIN_LIM) ? MIN_LIM : limit;
  assign last = ({1'b0, count_q} + (CNT_W+1)'(1)) >= {1'b0, eff};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      count_q <= '0;
    else if (clear)                  count_q <= '0;
    else if (inc && count_q != SAT)  count_q <= count_q + CNT_W'(1);
  end
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import ftp_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          CNT_W      = 16,
  parameter int          TOG_POS    = 6,
  parameter int          TMO_POS    = 5,
  parameter logic [7:0]  RESET_CODE = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [CNT_W-1:0]  max_polls,
  output logic              rd_req,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DATA_W-1:0] cmd_data,
  output logic              done,
  output logic              fail,
  output logic              busy
);
  ftp_state_e   state_q;
  ftp_verdict_e verdict;
  logic         ref_q, done_q, fail_q;
  logic         budget_last, rd_take;

  ftp_judge #(.DATA_W(DATA_W), .TOG_POS(TOG_POS), .TMO_POS(TMO_POS)) u_judge (
    .ref_bit(ref_q), .word(rd_data), .verdict(verdict)
  );

  assign rd_take = rd_req && rd_done && !abort;

  ftp_budget #(.CNT_W(CNT_W)) u_budget (
    .clk(clk), .rst_n(rst_n),
    .clear(state_q == ST_IDLE && start),
    .inc(rd_take),
    .limit(max_polls),
    .last(budget_last)
  );

  assign rd_req    = (state_q == ST_FIRST) || (state_q == ST_NEXT) ||
                     (state_q == ST_RE_A)  || (state_q == ST_RE_B);
  assign cmd_valid = (state_q == ST_RSTCMD);
  assign cmd_data  = DATA_W'(RESET_CODE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign fail      = fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ref_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          done_q  <= 1'b0;
          fail_q  <= 1'b0;
          state_q <= ST_FIRST;
        end
        ST_FIRST, ST_RE_A: begin
          if (abort) state_q <= ST_IDLE;
          else if (rd_done) begin
            ref_q   <= rd_data[TOG_POS];
            state_q <= (state_q == ST_FIRST) ? ST_NEXT : ST_RE_B;
          end
        end
        ST_NEXT: begin
          if (abort) state_q <= ST_IDLE;
          else if (rd_done) begin
            unique case (verdict)
              V_STEADY:     begin done_q <= 1'b1; state_q <= ST_IDLE; end
              V_TOGGLE_TMO: state_q <= ST_RE_A;
              default: begin
                ref_q <= rd_data[TOG_POS];
                if (budget_last) state_q <= ST_RSTCMD;
              end
            endcase
          end
        end
        ST_RE_B: begin
          if (abort) state_q <= ST_IDLE;
          else if (rd_done) begin
            if (verdict == V_STEADY) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_RSTCMD;
            end
          end
        end
        ST_RSTCMD: if (cmd_ready) begin
          fail_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && rd_req && !done && !fail));
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_done && !abort) |=> rd_req);
  // R7
  cmd_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && cmd_valid));
  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid);
  // R8
  cmd_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (fail && !busy));
  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && rd_req) |=> (!busy && !done && !fail));
  // R11
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: tb/test_flash_toggle_poller.sv
module test_flash_toggle_poller;
  localparam int DW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0, rd_done = 1'b0, cmd_ready = 1'b0;
  logic [CW-1:0] max_polls = 8'd100;
  logic [DW-1:0] rd_data = '0;
  logic rd_req, cmd_valid, done, fail, busy;
  logic [DW-1:0] cmd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  flash_toggle_poller #(.DATA_W(DW), .CNT_W(CW)) i_flash_toggle_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .max_polls(max_polls),
    .rd_req(rd_req), .rd_done(rd_done), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .done(done), .fail(fail), .busy(busy)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R3 watchdog: actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2", "busy after start", busy, 1);
    chk("R2", "rd_req after start", rd_req, 1);
    chk("R2", "done/fail cleared", {done, fail}, 0);
  endtask

  task automatic serve(input logic [7:0] d);
    while (!rd_req) @(negedge clk);
    rd_data = d; rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "outputs after reset", {busy, done, fail, rd_req, cmd_valid}, 0);
  endtask

  task automatic t_quick_done();
    kick();
    @(negedge clk); @(negedge clk);
    chk("R3", "rd_req held while waiting", rd_req, 1);
    serve(8'h5F);
    chk("R4", "no decision on first read", {done, rd_req}, 1);
    serve(8'h40);
    chk("R4", "done after steady pair", done, 1);
    chk("R4", "no more reads", {busy, rd_req}, 0);
    repeat (5) @(negedge clk);
    chk("R11", "done held", {done, fail}, 2);
    kick();
    serve(8'h00);
    serve(8'h00);
    chk("R4", "done with bit6 low", done, 1);
  endtask

  task automatic t_continue();
    kick();
    serve(8'h00);
    serve(8'h40);
    chk("R5", "toggle no timeout keeps reading", {done, rd_req}, 1);
    serve(8'h00);
    chk("R5", "compares with prior read", {done, rd_req}, 1);
    serve(8'h00);
    chk("R5", "done after settling", {done, busy}, 2);
  endtask

  task automatic t_recheck_ok();
    kick();
    serve(8'h00);
    serve(8'h60);
    chk("R6", "recheck reads begin", {done, fail, rd_req}, 1);
    serve(8'h40);
    chk("R6", "no decision on first recheck", {done, rd_req}, 1);
    serve(8'h40);
    chk("R6", "done after steady recheck", {done, fail, busy}, 4);
  endtask

  task automatic t_recheck_fail();
    kick();
    serve(8'h00);
    serve(8'h60);
    serve(8'h00);
    serve(8'h40);
    chk("R7", "reset command raised", cmd_valid, 1);
    chk("R7", "reset code", cmd_data, 8'hF0);
    chk("R7", "reads stopped", rd_req, 0);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    @(negedge clk);
    chk("R12", "abort ignored during command", {cmd_valid, busy}, 3);
    chk("R8", "command held under back-pressure", cmd_data, 8'hF0);
    cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
    chk("R8", "fail after handshake", {fail, done, busy, cmd_valid}, 8);
    repeat (4) @(negedge clk);
    chk("R11", "fail held", fail, 1);
  endtask

  task automatic t_budget();
    max_polls = 8'd4;
    kick();
    serve(8'h00);
    serve(8'h40);
    serve(8'h00);
    chk("R9", "below budget still reading", {rd_req, cmd_valid}, 2);
    serve(8'h40);
    chk("R9", "budget exhausted -> command", {rd_req, cmd_valid}, 1);
    cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
    chk("R9", "fail on budget", fail, 1);
    max_polls = 8'd1;
    kick();
    chk("R11", "fail cleared by start", fail, 0);
    serve(8'h00);
    serve(8'h40);
    chk("R9", "small limit acts as 2", {rd_req, cmd_valid}, 1);
    cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
    max_polls = 8'd100;
  endtask

  task automatic t_abort();
    kick();
    serve(8'h00);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R10", "idle after abort", {busy, rd_req, done, fail}, 0);
    kick();
    serve(8'h00);
    chk("R10", "restart takes fresh first read", {done, rd_req}, 1);
    serve(8'h40);
    chk("R10", "restart pair compared fresh", {done, rd_req}, 1);
    serve(8'h40);
    chk("R10", "restart then completes", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_quick_done();
    t_continue();
    t_recheck_ok();
    t_recheck_fail();
    t_budget();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule